// File: doc/BRIEF.md
# Second-Order Sinc Decimator

This block turns the one-bit output of a first-order delta-sigma modulator into 16-bit PCM words. The structure is a cascaded integrator-comb filter of order two. Two integrators run at the oversampled rate on the rising edge of `clk`. A divide-by-256 counter, also on the rising edge, marks every 256th input cycle. On the falling edge of that cycle, two comb differentiators and an output register take one new sample. So with a 5.12 MHz modulator clock, a new word appears at 20 kHz.

All datapath storage and arithmetic is W = ORDER x log2(ratio) = 16 bits wide, and it wraps modulo 2^16 without saturation. Both comb subtractions settle combinationally inside one output period. The design places the output update half a modulator cycle after the integrator update, so the combs always read settled integrator state. The filter's DC gain is 256 x 256 = 65536, which equals the modulus. A stream with k ones in every 256 bits therefore settles to (256*k) mod 65536, and a stream of all ones reads as zero.

Top module: `cic2_decimator`

## Requirements
- R1: Each input bit is weighted 1 for a one and 0 for a zero, and this weight is added into the first integrator on every rising clock edge. A stream of all zeros gives an output of 0, and a stream with one 1 in every 256 bits gives 256.
- R2: Suppose the input carries exactly k ones in every 256 consecutive bits (0 <= k <= 256). Then, counting from the first strobe after the density took effect, every strobe from the third onward presents `pcm_out` = (256*k) mod 65536.
- R3: `pcm_valid` stays high for exactly one `clk` period per output sample.
- R4: Consecutive rising transitions of `pcm_valid` are exactly 256 `clk` periods apart.
- R5: `pcm_out` and `pcm_valid` change only on the falling edge of `clk`. A new strobe is therefore never visible in the half period that follows a rising edge before the falling edge.
- R6: `pcm_out` holds its value between strobes.
- R7: While `rst_n` is low, `pcm_out` and `pcm_valid` are 0. After reset is released, the first strobe appears on the falling edge that follows the 255th rising edge.
- R8: The integrators wrap modulo 2^16. Steady-state outputs stay correct after the integrators have overflowed many times, and a full-density stream (k = 256) reads as 0.
- R9: Asserting `rst_n` low in the middle of a run immediately clears a nonzero output to 0 and restarts the decimation phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oversampled modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mod_bit | input | 1 | One-bit modulator output, sampled on the rising edge |
| pcm_out | output | 16 | Decimated sample, unsigned modulo 2^16 |
| pcm_valid | output | 1 | One-cycle strobe marking a new sample |

## Verification
The bench sweeps the pulse density k across its whole range in steps and adds the end values 1, 255 and 256. It drives each density as an evenly spread periodic pattern, with no reset between settings, so the integrators overflow again and again. A design that saturated instead of wrapping, or that mapped the bit with a different weight, would drift away from 256*k. A design that misplaced a comb delay would show the wrong value after the two-sample transient. The bench also tracks the strobe at quarter-period points on both edges, so an update moved onto the rising edge is caught, and so is a strobe that is wider than one cycle or that comes after a miscounted ratio. Finally it checks the first-strobe timing after reset and an asynchronous reset in the middle of a run.

// File: rtl/cic2_pkg.sv
package cic2_pkg;
  localparam int DEF_RATIO_LOG2 = 8;
  localparam int DEF_ORDER      = 2;

  // Number of input cycles per output sample.
  function automatic int unsigned decim_ratio(input int unsigned ratio_log2);
    return 32'd1 << ratio_log2;
  endfunction

  // Datapath width needed for lossless modulo growth.
  function automatic int unsigned path_width(input int unsigned order,
                                             input int unsigned ratio_log2);
    return order * ratio_log2;
  endfunction
endpackage

// File: rtl/cic2_rate_gen.sv
module cic2_rate_gen #(
  parameter int RATIO_LOG2 = cic2_pkg::DEF_RATIO_LOG2
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  logic [RATIO_LOG2-1:0] phase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_q + 1'b1;
  end

  // High during the last input cycle of each decimation frame.
  assign tick = &phase_q;
endmodule

// File: rtl/cic2_integ.sv
module cic2_integ #(
  parameter int ORDER = cic2_pkg::DEF_ORDER,
  parameter int W     = 16
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      bit_in,
  output logic [ORDER-1:0][W-1:0]   acc_q
);
  function automatic logic [W-1:0] wrap_add(input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    return a + b;
  endfunction

  function automatic logic [W-1:0] bit_weight(input logic b);
    return {{(W-1){1'b0}}, b};
  endfunction

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    logic [W-1:0] addend;
    logic [W-1:0] sum_q;

    if (g == 0) begin : g_head
      assign addend = bit_weight(bit_in);
    end else begin : g_link
      assign addend = acc_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sum_q <= '0;
      else        sum_q <= wrap_add(sum_q, addend);
    end

    assign acc_q[g] = sum_q;
  end
endmodule

// File: rtl/cic2_comb.sv
module cic2_comb #(
  parameter int ORDER = cic2_pkg::DEF_ORDER,
  parameter int W     = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         dout_valid
);
  function automatic logic [W-1:0] wrap_sub(input logic [W-1:0] a,
                                            input logic [W-1:0] b);
    return a - b;
  endfunction

  logic [ORDER:0][W-1:0] chain;
  assign chain[0] = din;

  // Differentiators chained combinationally; delays load on the falling edge.
  for (genvar g = 0; g < ORDER; g++) begin : g_diff
    logic [W-1:0] delay_q;

    always_ff @(negedge clk or negedge rst_n) begin
      if (!rst_n)  delay_q <= '0;
      else if (en) delay_q <= chain[g];
    end

    assign chain[g+1] = wrap_sub(chain[g], delay_q);
  end

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout       <= '0;
      dout_valid <= 1'b0;
    end else begin
      dout_valid <= en;
      if (en) dout <= chain[ORDER];
    end
  end
endmodule

// File: rtl/cic2_decimator.sv
module cic2_decimator #(
  parameter  int RATIO_LOG2 = cic2_pkg::DEF_RATIO_LOG2,
  parameter  int ORDER      = cic2_pkg::DEF_ORDER,
  localparam int W          = ORDER * RATIO_LOG2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         mod_bit,
  output logic [W-1:0] pcm_out,
  output logic         pcm_valid
);
  logic                    dec_tick;
  logic [ORDER-1:0][W-1:0] integ_q;
  logic [W-1:0]            integ_head;
  logic [W-1:0]            integ_tail;

  assign integ_head = integ_q[0];
  assign integ_tail = integ_q[ORDER-1];

  cic2_rate_gen #(.RATIO_LOG2(RATIO_LOG2)) u_rate (
    .clk   (clk),
    .rst_n (rst_n),
    .tick  (dec_tick)
  );

  cic2_integ #(.ORDER(ORDER), .W(W)) u_integ (
    .clk    (clk),
    .rst_n  (rst_n),
    .bit_in (mod_bit),
    .acc_q  (integ_q)
  );

  cic2_comb #(.ORDER(ORDER), .W(W)) u_comb (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (dec_tick),
    .din        (integ_tail),
    .dout       (pcm_out),
    .dout_valid (pcm_valid)
  );
endmodule

// File: rtl/cic2_decimator_chk.sv
module cic2_decimator_chk #(
  parameter int RATIO_LOG2 = 8,
  parameter int ORDER      = 2,
  localparam int W         = ORDER * RATIO_LOG2,
  localparam int RATIO     = 1 << RATIO_LOG2
) (
  input logic         clk,
  input logic         rst_n,
  input logic         mod_bit,
  input logic [W-1:0] integ_head,
  input logic [W-1:0] pcm_out,
  input logic         pcm_valid
);
  logic [31:0] gap_q;
  logic        seen_q;

  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_q  <= '0;
      seen_q <= 1'b0;
    end else if (pcm_valid) begin
      gap_q  <= '0;
      seen_q <= 1'b1;
    end else begin
      gap_q  <= gap_q + 1;
    end
  end

  // R1: the first integrator advances by the weight of the previous input bit
  a_r1_integ_step: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> integ_head == W'($past(integ_head) + W'($past(mod_bit))));

  // R3: strobe never lasts two periods
  a_r3_strobe_single: assert property (@(negedge clk) disable iff (!rst_n)
    pcm_valid |=> !pcm_valid);

  // R4: strobes are one decimation frame apart
  a_r4_strobe_period: assert property (@(negedge clk) disable iff (!rst_n)
    (pcm_valid && seen_q) |-> gap_q == RATIO - 1);

  // R6: output holds while no strobe is pending
  a_r6_hold: assert property (@(negedge clk) disable iff (!rst_n)
    !pcm_valid |-> $stable(pcm_out));
endmodule

bind cic2_decimator cic2_decimator_chk #(.RATIO_LOG2(RATIO_LOG2), .ORDER(ORDER)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mod_bit    (mod_bit),
  .integ_head (integ_head),
  .pcm_out    (pcm_out),
  .pcm_valid  (pcm_valid)
);

// File: tb/sim_cic2_decimator.sv
module sim_cic2_decimator;
  localparam int PERIOD = 10;
  localparam int FRAME  = 256;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mod_bit = 1'b0;
  logic [15:0] pcm_out;
  logic        pcm_valid;

  int checks = 0;
  int errors = 0;
  int dens = 0;
  int phase = 0;
  int since = 0;
  int nsamp = 0;
  logic [15:0] cap = '0;
  bit have_cap = 0;
  bit a_valid = 0;
  bit b_valid = 0;
  bit after_reset = 0;
  bit finished = 0;

  cic2_decimator u0 (
    .clk       (clk),
    .rst_n     (rst_n),
    .mod_bit   (mod_bit),
    .pcm_out   (pcm_out),
    .pcm_valid (pcm_valid)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One clk period: sample after the rising edge, drive, sample after the falling edge.
  task automatic cycle();
    @(posedge clk); #(PERIOD/4);
    a_valid = pcm_valid;
    if (b_valid) chk(a_valid, "R3 strobe second half", int'(a_valid), 1);
    if (have_cap) chk(pcm_out == cap, "R6 hold after rise", int'(pcm_out), int'(cap));
    phase = phase + dens;
    mod_bit = (phase >= FRAME);
    phase = phase % FRAME;
    @(negedge clk); #(PERIOD/4);
    since++;
    if (pcm_valid && !b_valid) begin
      chk(!a_valid, "R5 update on falling edge", int'(a_valid), 0);
      if (after_reset && nsamp == 0)
        chk(since == FRAME - 1, "R7 first strobe timing", since, FRAME - 1);
      else if (nsamp > 0)
        chk(since == FRAME, "R4 strobe spacing", since, FRAME);
      cap = pcm_out;
      have_cap = 1;
      nsamp++;
      since = 0;
    end else if (b_valid) begin
      chk(!pcm_valid, "R3 strobe width", int'(pcm_valid), 0);
    end else if (have_cap) begin
      chk(pcm_out == cap, "R6 hold after fall", int'(pcm_out), int'(cap));
    end
    b_valid = pcm_valid;
  endtask

  task automatic wait_samples(input int n);
    int target;
    target = nsamp + n;
    while (nsamp < target) cycle();
  endtask

  task automatic apply_reset();
    @(negedge clk); #(PERIOD/4);
    rst_n = 1'b0;
    #1;
    chk(pcm_out == 16'd0, "R9 async clear of output", int'(pcm_out), 0);
    chk(pcm_valid == 1'b0, "R7 strobe low in reset", int'(pcm_valid), 0);
    repeat (3) @(posedge clk);
    @(negedge clk); #(PERIOD/4);
    rst_n = 1'b1;
    since = 0; nsamp = 0; have_cap = 0; b_valid = 0; phase = 0;
    after_reset = 1;
  endtask

  task automatic run_density(input int k, input string req);
    int exp;
    dens = k;
    wait_samples(3);
    exp = (256 * k) % 65536;
    chk(int'(cap) == exp, req, int'(cap), exp);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #(PERIOD/4);
    chk(pcm_out == 16'd0, "R7 output zero in reset", int'(pcm_out), 0);
    chk(pcm_valid == 1'b0, "R7 strobe zero in reset", int'(pcm_valid), 0);
    apply_reset();

    run_density(0, "R1 all-zero stream");
    run_density(1, "R1 single one per frame");
    for (int k = 2; k <= 254; k += 4) run_density(k, "R2 density sweep");
    run_density(3, "R2 odd density");
    run_density(255, "R8 near full scale after wraps");
    run_density(256, "R8 full density wraps to zero");
    run_density(128, "R2 half density");

    // Mid-run reset with a nonzero output
    run_density(100, "R2 before reset");
    apply_reset();
    dens = 0;
    wait_samples(3);
    chk(cap == 16'd0, "R9 restart after reset", int'(cap), 0);
    run_density(77, "R2 after restart");

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule